// File: doc/BRIEF.md
# Bus-Activity Watchdog Timer

This block is a watchdog timer that needs no dedicated service pin. It listens to the clock and data lines of a two-wire serial bus and treats any completed bus transaction as a sign that the host processor is alive. A transaction counts as complete when a START condition is followed by at least one SCL low-then-high cycle and then a STOP condition. Each such transaction restarts the timeout counter. If no transaction completes before the counter runs out, the watchdog output goes high and stays high.

Both bus lines pass through a two-flop synchroniser before any edge detection. A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A two-bit period field chooses between three timeouts set by parameters. The fourth code switches the watchdog off. A host write port replaces the period field and also restarts the counter, so the new period counts from the write. The current period field is visible on an output.

Top module: `bus_watchdog`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `wdt_o` is 0 and `period_o` equals the INIT_PERIOD parameter (default 2'b00).
- R2: With no restart, `wdt_o` rises a fixed number of cycles after the last restart. Period code 2'b00 selects TMO_A cycles, 2'b01 selects TMO_B cycles and 2'b10 selects TMO_C cycles.
- R3: A bus sequence of START, then SCL low, then SCL high, then STOP clears `wdt_o` and restarts the timeout. This holds for the minimal sequence and for a full byte transfer.
- R4: A START followed by a STOP with no SCL low-then-high cycle between them does not clear `wdt_o` and does not restart the timeout.
- R5: SDA edges while SCL is low are neither START nor STOP. A sequence whose only SDA fall happens with SCL low, even when it ends in a real STOP, does not restart the timeout.
- R6: Once `wdt_o` is 1 it stays 1 until a valid bus sequence (R3), a period write (R7) or a reset.
- R7: When `cfg_we` is 1 at a clock edge, `period_o` takes `cfg_wdata` from that edge on. `wdt_o` is cleared, and the timeout restarts with the new period.
- R8: Period code 2'b11 disables the watchdog: `wdt_o` is 0 and never rises while the code is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sda_i | input | 1 | Serial data line, asynchronous to clk |
| scl_i | input | 1 | Serial clock line, asynchronous to clk |
| cfg_we | input | 1 | Period field write strobe |
| cfg_wdata | input | 2 | New period code |
| period_o | output | 2 | Current period code |
| wdt_o | output | 1 | Watchdog expired, registered, sticky |

## Verification
The assertions assume that `cfg_we` is a single-cycle strobe. They also assume that the bus lines change slowly compared with `clk`, so that each synchronised SDA or SCL level lasts several cycles and no START and STOP land in the same cycle. The bench keeps to these assumptions. It holds every bus phase for four clock cycles, changes the lines only just after a falling clock edge, keeps both lines high during reset and raises `cfg_we` for exactly one cycle. Expected expiry times are checked with margins of a few cycles around the synchroniser and detector latency.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

  typedef enum logic [1:0] {
    PER_A   = 2'b00,
    PER_B   = 2'b01,
    PER_C   = 2'b10,
    PER_OFF = 2'b11
  } period_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_START = 2'd1,
    SQ_LOW   = 2'd2,
    SQ_HIGH  = 2'd3
  } seq_e;

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/bwd_sync.sv
module bwd_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL}};
      else     chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/bwd_seq_detect.sv
module bwd_seq_detect
  import bwd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sda_s,
  input  logic scl_s,
  output logic kick
);

  logic sda_q, scl_q;
  logic start_c, stop_c;
  seq_e state, state_nx;

  // Conditions only count while SCL is high in this sample and the last one
  assign start_c = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c  = scl_s & scl_q & ~sda_q & sda_s;

  always_comb begin
    state_nx = state;
    if (start_c) begin
      state_nx = SQ_START;
    end else if (stop_c) begin
      state_nx = SQ_IDLE;
    end else begin
      case (state)
        SQ_START: if (!scl_s) state_nx = SQ_LOW;
        SQ_LOW:   if (scl_s)  state_nx = SQ_HIGH;
        default:  state_nx = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
      state <= SQ_IDLE;
      kick  <= 1'b0;
    end else begin
      sda_q <= sda_s;
      scl_q <= scl_s;
      state <= state_nx;
      kick  <= stop_c & (state == SQ_HIGH);
    end
  end

endmodule

// File: rtl/bwd_timer.sv
module bwd_timer
  import bwd_pkg::*;
#(
  parameter int unsigned TMO_A = 200,
  parameter int unsigned TMO_B = 400,
  parameter int unsigned TMO_C = 700
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic [1:0] period,
  output logic       expired
);

  localparam int unsigned TMAX = max3(TMO_A, TMO_B, TMO_C);
  localparam int unsigned CW   = $clog2(TMAX + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          off;

  always_comb begin
    off  = 1'b0;
    last = CW'(TMO_A - 1);
    case (period_e'(period))
      PER_A:   last = CW'(TMO_A - 1);
      PER_B:   last = CW'(TMO_B - 1);
      PER_C:   last = CW'(TMO_C - 1);
      default: off  = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || restart || off) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (!expired) begin
      if (cnt == last) expired <= 1'b1;
      else             cnt     <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog
  import bwd_pkg::*;
#(
  parameter int unsigned TMO_A       = 200,
  parameter int unsigned TMO_B       = 400,
  parameter int unsigned TMO_C       = 700,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [1:0]  INIT_PERIOD = 2'b00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sda_i,
  input  logic       scl_i,
  input  logic       cfg_we,
  input  logic [1:0] cfg_wdata,
  output logic [1:0] period_o,
  output logic       wdt_o
);

  logic [1:0] bus_s;
  logic       kick;
  logic [1:0] period_q;

  bwd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_i, sda_i}),
    .q   (bus_s)
  );

  bwd_seq_detect u_det (
    .clk   (clk),
    .rst   (rst),
    .sda_s (bus_s[0]),
    .scl_s (bus_s[1]),
    .kick  (kick)
  );

  always_ff @(posedge clk) begin
    if (rst)         period_q <= INIT_PERIOD;
    else if (cfg_we) period_q <= cfg_wdata;
  end

  bwd_timer #(.TMO_A(TMO_A), .TMO_B(TMO_B), .TMO_C(TMO_C)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .restart (kick | cfg_we),
    .period  (period_q),
    .expired (wdt_o)
  );

  assign period_o = period_q;

endmodule

// File: rtl/bwd_checker.sv
module bwd_checker (
  input logic       clk,
  input logic       rst,
  input logic       kick,
  input logic       cfg_we,
  input logic [1:0] cfg_wdata,
  input logic [1:0] period_o,
  input logic       wdt_o
);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (wdt_o && !kick && !cfg_we) |=> wdt_o);

  assert_kick_clears_R3: assert property (@(posedge clk) disable iff (rst)
    kick |=> !wdt_o);

  assert_kick_single_R3: assert property (@(posedge clk) disable iff (rst)
    kick |=> !kick);

  assert_write_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (!wdt_o && period_o == $past(cfg_wdata)));

  assert_period_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(period_o));

  assert_disabled_R8: assert property (@(posedge clk) disable iff (rst)
    (period_o == 2'b11) |-> !wdt_o);

  assert_rise_cause_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_o) |-> $past(!kick && !cfg_we));

endmodule

bind bus_watchdog bwd_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .kick      (kick),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .period_o  (period_o),
  .wdt_o     (wdt_o)
);

// File: tb/bus_watchdog_tb.sv
`timescale 1ns/1ps
module bus_watchdog_tb;

  localparam int TA = 200;
  localparam int TB = 400;
  localparam int TC = 700;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sda = 1'b1;
  logic       scl = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_wdata = 2'b00;
  logic [1:0] period_o;
  logic       wdt_o;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int last_stop = 0;
  bit done = 0;

  typedef struct {
    int    at;
    logic  val;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_watchdog #(.TMO_A(TA), .TMO_B(TB), .TMO_C(TC)) u_dut (
    .clk(clk), .rst(rst), .sda_i(sda), .scl_i(scl),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .period_o(period_o), .wdt_o(wdt_o)
  );

  // driver side: schedule an expected wdt_o value at an absolute cycle
  task automatic expect_wdt(input int at, input logic v, input string tag);
    exp_t e;
    e.at = at; e.val = v; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: pops matching entries and compares
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        checks++;
        if (wdt_o !== sb[i].val) begin
          errors++;
          $display("FAIL %s: wdt_o=%0b expected %0b at cycle %0d",
                   sb[i].tag, wdt_o, sb[i].val, cyc);
        end
        sb.delete(i);
      end
    end
  end

  task automatic check_period(input logic [1:0] e, input string tag);
    checks++;
    if (period_o !== e) begin
      errors++;
      $display("FAIL %s: period_o=%0b expected %0b", tag, period_o, e);
    end
  endtask

  task automatic step();
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_start();
    sda = 1'b1; scl = 1'b1; step();
    sda = 1'b0; step();
  endtask

  task automatic bus_bit(input logic b);
    scl = 1'b0; step();
    sda = b;    step();
    scl = 1'b1; step();
  endtask

  task automatic bus_stop();
    scl = 1'b0; step();
    sda = 1'b0; step();
    scl = 1'b1; step();
    sda = 1'b1; last_stop = cyc; step();
  endtask

  task automatic wait_until(input int at);
    while (cyc < at) @(negedge clk);
  endtask

  task automatic write_period(input logic [1:0] p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = p;
    last_stop = cyc;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin : watchdog
    repeat (30000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, got %0d pending expected 0", sb.size());
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int c0;
    repeat (5) @(negedge clk);
    // R1: reset state
    checks++;
    if (wdt_o !== 1'b0) begin
      errors++; $display("FAIL R1: wdt_o=%0b expected 0", wdt_o);
    end
    check_period(2'b00, "R1");
    rst = 1'b0; c0 = cyc;
    @(negedge clk);
    checks++;
    if (wdt_o !== 1'b0) begin
      errors++; $display("FAIL R1: wdt_o=%0b expected 0 after release", wdt_o);
    end

    // R2: idle bus expires after TMO_A; R6: stays high
    expect_wdt(c0 + TA - 3, 1'b0, "R2");
    expect_wdt(c0 + TA + 3, 1'b1, "R2");
    expect_wdt(c0 + TA + 150, 1'b1, "R6");
    wait_until(c0 + TA + 160);

    // R3: minimal sequence START, SCL low, SCL high, STOP
    bus_start();
    bus_stop();
    expect_wdt(last_stop + 7, 1'b0, "R3");
    expect_wdt(last_stop + TA, 1'b0, "R3");
    expect_wdt(last_stop + TA + 10, 1'b1, "R3");
    wait_until(last_stop + TA + 20);

    // R4: START then STOP directly while expired; no clear
    bus_start();
    sda = 1'b1; last_stop = cyc; step();
    expect_wdt(last_stop + 20, 1'b1, "R4");
    wait_until(last_stop + 25);

    // R5: SDA falls while SCL low, clock cycles, real STOP; no clear
    scl = 1'b0; step();
    sda = 1'b0; step();
    scl = 1'b1; step();
    scl = 1'b0; step();
    scl = 1'b1; step();
    sda = 1'b1; last_stop = cyc; step();
    expect_wdt(last_stop + 20, 1'b1, "R5");
    wait_until(last_stop + 25);

    // R3: full byte 0xA5 plus ack
    bus_start();
    for (int i = 7; i >= 0; i--) bus_bit(((8'hA5 >> i) & 1) != 0);
    bus_bit(1'b0);
    bus_stop();
    c0 = last_stop;
    expect_wdt(c0 + 7, 1'b0, "R3");
    wait_until(c0 + TA / 2);
    // R4: invalid sequence mid-period must not move the expiry
    bus_start();
    sda = 1'b1; step();
    expect_wdt(c0 + TA, 1'b0, "R4");
    expect_wdt(c0 + TA + 10, 1'b1, "R4");
    wait_until(c0 + TA + 20);

    // R7 / R2: write period 01
    write_period(2'b01);
    check_period(2'b01, "R7");
    expect_wdt(last_stop + 3, 1'b0, "R7");
    expect_wdt(last_stop + TB - 2, 1'b0, "R2");
    expect_wdt(last_stop + TB + 4, 1'b1, "R2");
    wait_until(last_stop + TB + 10);

    // R7 / R2: write period 10
    write_period(2'b10);
    check_period(2'b10, "R7");
    expect_wdt(last_stop + 3, 1'b0, "R7");
    expect_wdt(last_stop + TC - 2, 1'b0, "R2");
    expect_wdt(last_stop + TC + 4, 1'b1, "R2");
    wait_until(last_stop + TC + 10);

    // R8: code 11 disables
    write_period(2'b11);
    check_period(2'b11, "R8");
    expect_wdt(last_stop + 3, 1'b0, "R8");
    expect_wdt(last_stop + TC + 50, 1'b0, "R8");
    wait_until(last_stop + TC + 60);

    while (sb.size() != 0) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule